// File: doc/BRIEF.md
# Memory Card Host Interrupt Controller

This block gathers the interrupt events of a memory card host and drives a single active-high interrupt line toward the system interrupt controller. There are five kinds of source: a card-raised interrupt, a ready indication, a serial-interface event, a data-request event, and a group of pin-change events, one per monitored pin. Every source has its own sticky status flag. A chain of enable bits decides which pending flags may reach the interrupt line.

Taking the interrupt line down and clearing a status flag are two separate side effects. Each is triggered by a register access that the surrounding register file reports as a one-cycle strobe. A read of the interrupt status register acknowledges every flag that is pending at that moment, so the line drops while those flags stay visible. Each flag is then cleared by its own access: a command write, a data-port access that matches the transfer direction, the status read, or a pin register read. A fresh event on any source cancels that source's acknowledgement and raises the line again.

Top module: `cardIrqController`

## Requirements
- R1: After reset, all status flags and `irqOut` are 0.
- R2: An event pulse sampled at a clock edge sets the matching flag, which is visible right after that edge. The flag holds until its clear access occurs. When a set and a clear arrive in the same cycle, the set wins and the flag stays 1.
- R3: While `enGlobal` is 0, `irqOut` is 0 from the next edge on, whatever flags are pending.
- R4: The ready source reaches `irqOut` only when `enSerialIntr` is 1.
- R5: The serial-interface source reaches `irqOut` only when `enSerialIntr` is 1 and `autoCmdOff` is 0.
- R6: The data-request source reaches `irqOut` only when `drqSelect` is 1. The card source needs only `enGlobal`.
- R7: Pin bit i reaches `irqOut` only when `enPin` is 1 and bit i of `enPinMask` is 1.
- R8: `accStatusRd` clears the card flag.
- R9: `accCmdWr` clears both the ready flag and the serial-interface flag.
- R10: The serial-interface flag and the data-request flag are cleared by `accTxWr` while `xferIsRead` is 0, or by `accRxRd` while `xferIsRead` is 1. Either data-port access with the other direction leaves both flags unchanged.
- R11: `accPinRd` clears every pin flag.
- R12: `accStatusRd` acknowledges all flags that are pending, and `irqOut` is 0 two edges later. Acknowledged flags that have not been cleared stay 1. A new event on any source removes that source's acknowledgement.
- R13: `irqOut` is a register. After the edge at which a flag, an acknowledgement or an enable changes, it follows one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtCard | input | 1 | Card interrupt event pulse |
| evtReady | input | 1 | Ready event pulse |
| evtSerial | input | 1 | Serial-interface event pulse |
| evtDrq | input | 1 | Data-request event pulse |
| evtPin | input | NUM_PINS | Pin-change event pulses, one per pin |
| enGlobal | input | 1 | Global interrupt enable |
| enSerialIntr | input | 1 | Enable for the ready and serial-interface sources |
| autoCmdOff | input | 1 | 1 blocks the serial-interface source |
| drqSelect | input | 1 | 1 routes data requests to the interrupt line |
| enPin | input | 1 | Pin-change interrupt enable |
| enPinMask | input | NUM_PINS | Per-pin enable |
| accStatusRd | input | 1 | Strobe: interrupt status register read |
| accCmdWr | input | 1 | Strobe: command register write |
| accTxWr | input | 1 | Strobe: transmit data write |
| accRxRd | input | 1 | Strobe: receive data read |
| accPinRd | input | 1 | Strobe: pin register read |
| xferIsRead | input | 1 | Current transfer direction, 1 = read |
| flagCard | output | 1 | Card interrupt flag |
| flagReady | output | 1 | Ready flag |
| flagSerial | output | 1 | Serial-interface flag |
| flagDrq | output | 1 | Data-request flag |
| flagPin | output | NUM_PINS | Pin-change flags |
| irqOut | output | 1 | Interrupt line, active high |

## Verification
The hardest case to reach from the ports is a flag that stays set after it has been acknowledged. In that state the line is low even though a status bit reads 1, and only a new event may raise the line again. The stimulus first raises a ready flag and issues a status read. It then confirms that the flag is still 1 while the line is 0, and fires a data-request event so that the line rises again. A collision test drives an event together with its own clearing access in the same cycle, to show that the set wins. The direction-dependent clears are driven with matching and with opposite values of `xferIsRead`.

// File: rtl/cardIrqPkg.sv
package cardIrqPkg;

  // Fixed source positions in the unified flag vector; pins follow.
  localparam int IDX_CARD   = 0;
  localparam int IDX_READY  = 1;
  localparam int IDX_SERIAL = 2;
  localparam int IDX_DRQ    = 3;
  localparam int FIXED_SRCS = 4;

  // Strobes from control to datapath.
  typedef struct packed {
    logic clrCard;
    logic clrReady;
    logic clrSerial;
    logic clrDrq;
    logic clrPins;
    logic ackAll;
  } ctrlStrobesT;

endpackage

// File: rtl/cardIrqCtrl.sv
module cardIrqCtrl
  import cardIrqPkg::*;
#(
  parameter int NUM_PINS = 4,
  localparam int NSRC = FIXED_SRCS + NUM_PINS
) (
  input  logic                enGlobal,
  input  logic                enSerialIntr,
  input  logic                autoCmdOff,
  input  logic                drqSelect,
  input  logic                enPin,
  input  logic [NUM_PINS-1:0] enPinMask,
  input  logic                accStatusRd,
  input  logic                accCmdWr,
  input  logic                accTxWr,
  input  logic                accRxRd,
  input  logic                accPinRd,
  input  logic                xferIsRead,
  output ctrlStrobesT         strb,
  output logic [NSRC-1:0]     enMask
);

  logic dataXfer;

  // A data-port access counts only when it matches the transfer direction.
  assign dataXfer = (accTxWr & ~xferIsRead) | (accRxRd & xferIsRead);

  always_comb begin
    strb.clrCard   = accStatusRd;
    strb.clrReady  = accCmdWr;
    strb.clrSerial = accCmdWr | dataXfer;
    strb.clrDrq    = dataXfer;
    strb.clrPins   = accPinRd;
    strb.ackAll    = accStatusRd;
  end

  assign enMask[IDX_CARD]   = enGlobal;
  assign enMask[IDX_READY]  = enGlobal & enSerialIntr;
  assign enMask[IDX_SERIAL] = enGlobal & enSerialIntr & ~autoCmdOff;
  assign enMask[IDX_DRQ]    = enGlobal & drqSelect;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pinEn
    assign enMask[FIXED_SRCS+p] = enGlobal & enPin & enPinMask[p];
  end

endmodule

// File: rtl/cardIrqDatapath.sv
module cardIrqDatapath
  import cardIrqPkg::*;
#(
  parameter int NUM_PINS = 4,
  localparam int NSRC = FIXED_SRCS + NUM_PINS
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] setVec,
  input  logic [NSRC-1:0] enMask,
  input  ctrlStrobesT     strb,
  output logic [NSRC-1:0] flagQ,
  output logic            irqQ
);

  logic [NSRC-1:0] clrVec;
  logic [NSRC-1:0] ackQ;

  assign clrVec[IDX_CARD]   = strb.clrCard;
  assign clrVec[IDX_READY]  = strb.clrReady;
  assign clrVec[IDX_SERIAL] = strb.clrSerial;
  assign clrVec[IDX_DRQ]    = strb.clrDrq;
  assign clrVec[NSRC-1:FIXED_SRCS] = {NUM_PINS{strb.clrPins}};

  // One flag plus one acknowledge bit per source.
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rstN) begin
        flagQ[s] <= 1'b0;
        ackQ[s]  <= 1'b0;
      end else if (setVec[s]) begin
        flagQ[s] <= 1'b1;
        ackQ[s]  <= 1'b0;
      end else if (clrVec[s]) begin
        flagQ[s] <= 1'b0;
        ackQ[s]  <= 1'b0;
      end else if (strb.ackAll && flagQ[s]) begin
        ackQ[s]  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |(enMask & flagQ & ~ackQ);
  end

  assert_set_wins_R2: assert property (@(posedge clk) disable iff (!rstN)
    (setVec != '0) |=> ((flagQ & $past(setVec)) == $past(setVec)));

  assert_card_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrCard && !setVec[IDX_CARD]) |=> !flagQ[IDX_CARD]);

  assert_ack_drops_R12: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ackAll && setVec == '0) |=> ##1 !irqQ);

endmodule

// File: rtl/cardIrqController.sv
module cardIrqController
  import cardIrqPkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                evtCard,
  input  logic                evtReady,
  input  logic                evtSerial,
  input  logic                evtDrq,
  input  logic [NUM_PINS-1:0] evtPin,
  input  logic                enGlobal,
  input  logic                enSerialIntr,
  input  logic                autoCmdOff,
  input  logic                drqSelect,
  input  logic                enPin,
  input  logic [NUM_PINS-1:0] enPinMask,
  input  logic                accStatusRd,
  input  logic                accCmdWr,
  input  logic                accTxWr,
  input  logic                accRxRd,
  input  logic                accPinRd,
  input  logic                xferIsRead,
  output logic                flagCard,
  output logic                flagReady,
  output logic                flagSerial,
  output logic                flagDrq,
  output logic [NUM_PINS-1:0] flagPin,
  output logic                irqOut
);

  localparam int NSRC = FIXED_SRCS + NUM_PINS;

  ctrlStrobesT     strb;
  logic [NSRC-1:0] enMask;
  logic [NSRC-1:0] setVec;
  logic [NSRC-1:0] flagQ;

  assign setVec = {evtPin, evtDrq, evtSerial, evtReady, evtCard};

  cardIrqCtrl #(.NUM_PINS(NUM_PINS)) i_ctrl (
    .enGlobal    (enGlobal),
    .enSerialIntr(enSerialIntr),
    .autoCmdOff  (autoCmdOff),
    .drqSelect   (drqSelect),
    .enPin       (enPin),
    .enPinMask   (enPinMask),
    .accStatusRd (accStatusRd),
    .accCmdWr    (accCmdWr),
    .accTxWr     (accTxWr),
    .accRxRd     (accRxRd),
    .accPinRd    (accPinRd),
    .xferIsRead  (xferIsRead),
    .strb        (strb),
    .enMask      (enMask)
  );

  cardIrqDatapath #(.NUM_PINS(NUM_PINS)) i_dp (
    .clk   (clk),
    .rstN  (rstN),
    .setVec(setVec),
    .enMask(enMask),
    .strb  (strb),
    .flagQ (flagQ),
    .irqQ  (irqOut)
  );

  assign flagCard   = flagQ[IDX_CARD];
  assign flagReady  = flagQ[IDX_READY];
  assign flagSerial = flagQ[IDX_SERIAL];
  assign flagDrq    = flagQ[IDX_DRQ];
  assign flagPin    = flagQ[NSRC-1:FIXED_SRCS];

  assert_global_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    !enGlobal |=> !irqOut);

  assert_pin_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    (accPinRd && evtPin == '0) |=> (flagPin == '0));

endmodule

// File: tb/test_cardIrqController.sv
module test_cardIrqController;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rstN;
  logic evtCard, evtReady, evtSerial, evtDrq;
  logic [NP-1:0] evtPin;
  logic enGlobal, enSerialIntr, autoCmdOff, drqSelect, enPin;
  logic [NP-1:0] enPinMask;
  logic accStatusRd, accCmdWr, accTxWr, accRxRd, accPinRd, xferIsRead;
  logic flagCard, flagReady, flagSerial, flagDrq, irqOut;
  logic [NP-1:0] flagPin;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cardIrqController #(.NUM_PINS(NP)) i_cardIrqController (
    .clk(clk), .rstN(rstN),
    .evtCard(evtCard), .evtReady(evtReady), .evtSerial(evtSerial),
    .evtDrq(evtDrq), .evtPin(evtPin),
    .enGlobal(enGlobal), .enSerialIntr(enSerialIntr), .autoCmdOff(autoCmdOff),
    .drqSelect(drqSelect), .enPin(enPin), .enPinMask(enPinMask),
    .accStatusRd(accStatusRd), .accCmdWr(accCmdWr), .accTxWr(accTxWr),
    .accRxRd(accRxRd), .accPinRd(accPinRd), .xferIsRead(xferIsRead),
    .flagCard(flagCard), .flagReady(flagReady), .flagSerial(flagSerial),
    .flagDrq(flagDrq), .flagPin(flagPin), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Advance past the next rising edge; inputs change and outputs are sampled here.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    {evtCard, evtReady, evtSerial, evtDrq} = '0;
    evtPin = '0;
    enGlobal = 1'b1; enSerialIntr = 1'b1; autoCmdOff = 1'b0;
    drqSelect = 1'b1; enPin = 1'b1; enPinMask = '1;
    {accStatusRd, accCmdWr, accTxWr, accRxRd, accPinRd, xferIsRead} = '0;
    tick(); tick();
    rstN = 1'b1;
    tick();
  endtask

  task automatic testReset();
    doReset();
    check("R1 flags", {flagCard, flagReady, flagSerial, flagDrq, flagPin}, 0);
    check("R1 irq", irqOut, 0);
  endtask

  task automatic testCardPath();
    doReset();
    enSerialIntr = 1'b0; drqSelect = 1'b0; enPin = 1'b0;
    evtCard = 1'b1; tick(); evtCard = 1'b0;
    check("R2 card flag set", flagCard, 1);
    check("R13 irq lags flag", irqOut, 0);
    tick();
    check("R6 card needs only global", irqOut, 1);
    tick();
    check("R2 card sticky", flagCard, 1);
    accStatusRd = 1'b1; tick(); accStatusRd = 1'b0;
    check("R8 card cleared", flagCard, 0);
    tick();
    check("R12 irq dropped", irqOut, 0);
  endtask

  task automatic testReadyEnable();
    doReset();
    enSerialIntr = 1'b0;
    evtReady = 1'b1; tick(); evtReady = 1'b0;
    tick();
    check("R4 ready blocked", irqOut, 0);
    enSerialIntr = 1'b1; tick();
    check("R4 ready enabled", irqOut, 1);
    accCmdWr = 1'b1; tick(); accCmdWr = 1'b0;
    check("R9 ready cleared by cmd", flagReady, 0);
    tick();
    check("R9 irq after ready clear", irqOut, 0);
  endtask

  task automatic testSerialBlock();
    doReset();
    autoCmdOff = 1'b1;
    evtSerial = 1'b1; tick(); evtSerial = 1'b0;
    tick();
    check("R5 serial blocked by autoCmdOff", irqOut, 0);
    autoCmdOff = 1'b0; enSerialIntr = 1'b0; tick();
    check("R5 serial blocked by enable", irqOut, 0);
    enSerialIntr = 1'b1; tick();
    check("R5 serial enabled", irqOut, 1);
    accCmdWr = 1'b1; tick(); accCmdWr = 1'b0;
    check("R9 serial cleared by cmd", flagSerial, 0);
  endtask

  task automatic testDirection();
    doReset();
    evtSerial = 1'b1; evtDrq = 1'b1; tick(); evtSerial = 1'b0; evtDrq = 1'b0;
    xferIsRead = 1'b1; accTxWr = 1'b1; tick(); accTxWr = 1'b0;
    check("R10 tx write on read transfer ignored", {flagSerial, flagDrq}, 2'b11);
    xferIsRead = 1'b0; accRxRd = 1'b1; tick(); accRxRd = 1'b0;
    check("R10 rx read on write transfer ignored", {flagSerial, flagDrq}, 2'b11);
    accTxWr = 1'b1; tick(); accTxWr = 1'b0;
    check("R10 tx write clears", {flagSerial, flagDrq}, 2'b00);
    evtSerial = 1'b1; evtDrq = 1'b1; tick(); evtSerial = 1'b0; evtDrq = 1'b0;
    xferIsRead = 1'b1; accRxRd = 1'b1; tick(); accRxRd = 1'b0;
    check("R10 rx read clears", {flagSerial, flagDrq}, 2'b00);
    drqSelect = 1'b0;
    evtDrq = 1'b1; tick(); evtDrq = 1'b0;
    tick();
    check("R6 drq blocked", irqOut, 0);
    drqSelect = 1'b1; tick();
    check("R6 drq enabled", irqOut, 1);
  endtask

  task automatic testPins();
    doReset();
    enPinMask = 4'b0010;
    evtPin = 4'b0001; tick(); evtPin = '0;
    check("R2 pin0 flag", flagPin, 4'b0001);
    tick();
    check("R7 masked pin no irq", irqOut, 0);
    evtPin = 4'b0010; tick(); evtPin = '0;
    tick();
    check("R7 unmasked pin irq", irqOut, 1);
    enPin = 1'b0; tick();
    check("R7 pin enable off", irqOut, 0);
    accPinRd = 1'b1; tick(); accPinRd = 1'b0;
    check("R11 pin flags cleared", flagPin, 4'b0000);
  endtask

  task automatic testGlobalGate();
    doReset();
    enGlobal = 1'b0;
    evtCard = 1'b1; evtReady = 1'b1; evtDrq = 1'b1; evtPin = 4'b1111;
    tick();
    evtCard = 1'b0; evtReady = 1'b0; evtDrq = 1'b0; evtPin = '0;
    tick(); tick();
    check("R3 global off", irqOut, 0);
    enGlobal = 1'b1; tick();
    check("R13 irq one edge after enable", irqOut, 1);
  endtask

  task automatic testAckReassert();
    doReset();
    evtReady = 1'b1; tick(); evtReady = 1'b0;
    tick();
    check("R12 ready raised irq", irqOut, 1);
    accStatusRd = 1'b1; tick(); accStatusRd = 1'b0;
    check("R12 ready flag kept after ack", flagReady, 1);
    tick();
    check("R12 irq negated by status read", irqOut, 0);
    tick();
    check("R12 acked flag stays quiet", irqOut, 0);
    evtDrq = 1'b1; tick(); evtDrq = 1'b0;
    tick();
    check("R12 new event reasserts", irqOut, 1);
  endtask

  task automatic testSetWins();
    doReset();
    evtSerial = 1'b1; accCmdWr = 1'b1; tick();
    evtSerial = 1'b0; accCmdWr = 1'b0;
    check("R2 set beats cmd clear", flagSerial, 1);
    evtCard = 1'b1; accStatusRd = 1'b1; tick();
    evtCard = 1'b0; accStatusRd = 1'b0;
    check("R2 set beats status clear", flagCard, 1);
    tick();
    check("R12 event with ack stays unacked", irqOut, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    testReset();
    testCardPath();
    testReadyEnable();
    testSerialBlock();
    testDirection();
    testPins();
    testGlobalGate();
    testAckReassert();
    testSetWins();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule